// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with a small internal array. A command is presented on one rising clock edge. Its data moves exactly two active edges later, whether the command is a read or a write. Because both directions share the same fixed distance, a read may follow a write, or a write may follow a read, on consecutive edges with no idle cycle in between.

The array holds `2**ADDR_W` words, and each word is made of `LANES` lanes of `LANE_W` bits. Writes are lane-selective. A command that loads an address can be followed by advance cycles, which step through a four-word burst. The burst order is a build-time parameter: it is either linear (add and wrap) or interleaved (XOR). The shared data bus is modelled as three signals: a data-in port, a registered data-out port, and a drive-enable output.

A clock-enable input can freeze the whole machine, as can a sleep input. The asynchronous output enable only masks the drive-enable output.

Top module: `zbt_sram`

## Requirements
- R1: A read command loaded on an active edge (`advLd`=0, all enables true, `weN`=1) places `mem[addr]` on `dOut` after the second active edge that follows it. A write command (`weN`=0) stores `dIn` as it stands at that second following edge. Mixed reads and writes may be issued on consecutive edges, and each one still completes correctly.
- R2: An edge with `cenN`=1 ignores every synchronous input. On such an edge the pipeline, the burst state, the array and `dOut` all keep their values.
- R3: A load edge (`advLd`=0) with `ce1N`=1, `ce2`=0 or `ce3N`=1 is a deselect. It starts no access, and it ends any burst, so later advance edges start nothing.
- R4: Accesses already in the pipeline complete after a deselect. `dOutEn` is low after the second active edge that follows a deselect or a write command.
- R5: `bwN[i]`=0 enables lane i, which is bits `[i*LANE_W +: LANE_W]` (lane 0 holds the lowest bits). Lanes left disabled keep their stored value when the write completes.
- R6: The byte enables are sampled on every beat of a write burst, and each beat uses its own enables. The byte enables are ignored on read beats.
- R7: `oeN`=1 forces `dOutEn` low at once and does not disturb the pipeline. `dOutEn` is 1 exactly when the last completed active edge retired a read and `oeN`=0.
- R8: An edge with `sleep`=1 behaves like one with `cenN`=1. The array contents survive any number of sleep cycles.
- R9: An advance edge (`advLd`=1) during a burst issues beat n (n = 1, 2, 3, 0, ...) of the loaded access type. Its address keeps the upper bits of the loaded address. Its two low bits are (base+n) mod 4 when `INTERLEAVE`=0, and base XOR n when `INTERLEAVE`=1.
- R10: Reset (`rstN`=0, asynchronous) clears the array to zero, empties the pipeline, ends any burst and drives `dOutEn` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cenN | input | 1 | Active-low clock enable |
| sleep | input | 1 | High gates the internal clock |
| advLd | input | 1 | 0 loads a new command, 1 advances the burst |
| weN | input | 1 | 1 read, 0 write |
| ce1N | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3N | input | 1 | Active-low chip enable |
| bwN | input | LANES | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| oeN | input | 1 | Asynchronous active-low output enable |
| dIn | input | LANES*LANE_W | Write data, sampled at the data edge |
| dOut | output | LANES*LANE_W | Registered read data |
| dOutEn | output | 1 | Drive enable for the data bus |

## Verification
A corrupted pipeline stage shows up at the ports two active edges after the bad command, as wrong `dOut` data or as a wrong `dOutEn` level. The bench compares both outputs with a queue-based reference on every cycle, so such a fault is reported within three clocks. A wrong lane mask or a bad burst address stays hidden until the affected word is read back, which is why every write pattern is followed by reads of the same words. A freeze that leaks, under either clock enable or sleep, makes `dOut` change during the frozen window, and this is flagged on the very next cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  parameter int BEAT_BITS = 2;

  typedef struct packed {
    logic step;
    logic wrEn;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              sleep,
  input  logic              advLd,
  input  logic              weN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic [LANES-1:0]  bwN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memLanes
);
  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } entry_t;

  logic step, selected;
  entry_t stage1, stage2, nextEntry;
  logic burstOn, burstWr;
  logic [ADDR_W-1:0] burstBase;
  logic [BEAT_BITS-1:0] burstCnt, cntNext, beatLow;

  assign step     = !cenN && !sleep;
  assign selected = !ce1N && ce2 && !ce3N;
  assign cntNext  = burstCnt + 1'b1;

  generate
    if (INTERLEAVE) begin : g_xorOrder
      assign beatLow = burstBase[BEAT_BITS-1:0] ^ cntNext;
    end else begin : g_addOrder
      assign beatLow = burstBase[BEAT_BITS-1:0] + cntNext;
    end
  endgenerate

  always_comb begin
    nextEntry = '0;
    if (!advLd) begin
      if (selected) begin
        nextEntry.valid = 1'b1;
        nextEntry.write = !weN;
        nextEntry.addr  = addr;
        nextEntry.lanes = weN ? '0 : ~bwN;
      end
    end else if (burstOn) begin
      nextEntry.valid = 1'b1;
      nextEntry.write = burstWr;
      nextEntry.addr  = {burstBase[ADDR_W-1:BEAT_BITS], beatLow};
      nextEntry.lanes = burstWr ? ~bwN : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1    <= '0;
      stage2    <= '0;
      burstOn   <= 1'b0;
      burstWr   <= 1'b0;
      burstBase <= '0;
      burstCnt  <= '0;
    end else if (step) begin
      stage1 <= nextEntry;
      stage2 <= stage1;
      if (!advLd) begin
        burstOn   <= selected;
        burstWr   <= !weN;
        burstBase <= addr;
        burstCnt  <= '0;
      end else if (burstOn) begin
        burstCnt <= cntNext;
      end
    end
  end

  always_comb begin
    strb.step = step;
    strb.wrEn = step && stage2.valid && stage2.write;
    strb.rdEn = step && stage2.valid && !stage2.write;
    memAddr   = stage2.addr;
    memLanes  = stage2.lanes;
  end
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES-1:0]        memLanes,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic              outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (strb.wrEn) begin
      for (int i = 0; i < LANES; i++) begin
        if (memLanes[i]) mem[memAddr][i*LANE_W +: LANE_W] <= dIn[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      outValid <= 1'b0;
    end else if (strb.step) begin
      outValid <= strb.rdEn;
      if (strb.rdEn) rdData <= mem[memAddr];
    end
  end

  assign dOut   = rdData;
  assign dOutEn = outValid && !oeN;
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cenN,
  input  logic                    sleep,
  input  logic                    advLd,
  input  logic                    weN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic [LANES-1:0]        bwN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);
  strobe_t           strb;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  memLanes;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .INTERLEAVE(INTERLEAVE)) ctrl_i (
    .clk(clk), .rstN(rstN), .cenN(cenN), .sleep(sleep), .advLd(advLd), .weN(weN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .bwN(bwN), .addr(addr),
    .strb(strb), .memAddr(memAddr), .memLanes(memLanes)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr), .memLanes(memLanes),
    .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              cenN,
  input logic              sleep,
  input logic              advLd,
  input logic              weN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              oeN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn
);
  logic go, sel;
  assign go  = !cenN && !sleep;
  assign sel = !ce1N && ce2 && !ce3N;

  AST_READ_TWO_LATER: assert property (@(posedge clk) disable iff (!rstN)
    (go && !advLd && sel && weN) ##1 go ##1 go |=> (dOutEn || oeN)); // R1

  AST_FROZEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (cenN && !sleep) |=> $stable(dOut)); // R2

  AST_FLOAT_AFTER_DESEL_OR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (go && !advLd && (!sel || !weN)) ##1 go ##1 go |=> !dOutEn); // R4

  AST_OE_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dOutEn); // R7

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(dOut)); // R8
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) chk_i (.*);

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 0, rstN = 0, cenN = 0, sleep = 0, advLd = 0, weN = 1;
  logic ce1N = 1, ce2 = 1, ce3N = 0, oeN = 0;
  logic [NL-1:0] bwN = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutEn;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .INTERLEAVE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .cenN(cenN), .sleep(sleep), .advLd(advLd), .weN(weN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .bwN(bwN), .addr(addr), .oeN(oeN),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  typedef struct { bit v; bit w; int a; bit [NL-1:0] ln; } op_t;
  op_t pend[$];
  logic [DW-1:0] refMem [1 << AW];
  logic [DW-1:0] refOut;
  bit refValid;
  bit bOn, bWr;
  int bBase, bCnt;

  int checks = 0, fails = 0;
  string tag = "R10";
  bit done = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < (1 << AW); k++) refMem[k] = '0;
      pend.delete();
      pend.push_back('{0, 0, 0, '0});
      pend.push_back('{0, 0, 0, '0});
      refOut = '0; refValid = 0; bOn = 0; bWr = 0; bBase = 0; bCnt = 0;
    end else if (!cenN && !sleep) begin
      op_t e, old;
      bit s;
      e = '{0, 0, 0, '0};
      s = (ce1N == 0) && (ce2 == 1) && (ce3N == 0);
      if (advLd == 0) begin
        if (s) e = '{1, !weN, int'(addr), weN ? '0 : ~bwN};
        bOn = s; bWr = !weN; bBase = int'(addr); bCnt = 0;
      end else if (bOn) begin
        bCnt = (bCnt + 1) % 4;
        e = '{1, bWr, (bBase / 4) * 4 + ((bBase % 4) + bCnt) % 4, bWr ? ~bwN : '0};
      end
      pend.push_back(e);
      old = pend.pop_front();
      refValid = old.v && !old.w;
      if (old.v && old.w) begin
        for (int i = 0; i < NL; i++)
          if (old.ln[i]) refMem[old.a][i*LW +: LW] = dIn[i*LW +: LW];
      end
      if (refValid) refOut = refMem[old.a];
    end
  end

  task automatic compare();
    bit expEn;
    expEn = refValid && !oeN;
    checks++;
    if (dOutEn !== expEn) begin
      fails++;
      $display("FAIL %s dOutEn act=%0b exp=%0b at %0t", tag, dOutEn, expEn, $time);
    end
    if (expEn) begin
      checks++;
      if (dOut !== refOut) begin
        fails++;
        $display("FAIL %s dOut act=%h exp=%h at %0t", tag, dOut, refOut, $time);
      end
    end
  endtask

  // One clock: inputs set now, edge happens, outputs compared shortly after the falling edge
  task automatic cyc();
    dIn = {$urandom, $urandom};
    @(negedge clk);
    #2;
    if (rstN) compare();
  endtask

  // selc: 0 selected, 1 ce1N high, 2 ce2 low, 3 ce3N high
  task automatic ld(input bit rd, input int a, input logic [NL-1:0] bw, input int selc);
    advLd = 0; weN = rd; addr = AW'(a); bwN = bw;
    ce1N = (selc == 1); ce2 = (selc != 2); ce3N = (selc == 3);
    cyc();
  endtask

  task automatic adv(input logic [NL-1:0] bw);
    advLd = 1; bwN = bw; addr = AW'($urandom); weN = $urandom;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) ld(1, 0, '1, 1);
  endtask

  initial begin
    idle(0);
    repeat (3) @(negedge clk);
    rstN = 1;
    tag = "R10"; // reset state: read of untouched word returns zero
    idle(2);
    ld(1, 5, '1, 0); idle(3);

    tag = "R1"; // fill and back-to-back mixed traffic
    for (int i = 0; i < 8; i++) ld(0, i, 4'b0000, 0);
    for (int i = 0; i < 8; i++) begin ld(1, i, '1, 0); ld(0, 40 + i, 4'b0000, 0); end
    for (int i = 0; i < 8; i++) ld(1, 40 + i, '1, 0);
    idle(3);

    tag = "R5"; // partial lanes 0 and 2 (bwN=1010), then lane 3 only
    ld(0, 10, 4'b1010, 0); ld(0, 10, 4'b0111, 0); idle(1);
    ld(1, 10, '1, 0); idle(3);

    tag = "R6"; // burst write with new enables per beat, reads ignore enables
    ld(0, 32, 4'b0000, 0); adv(4'b1110); adv(4'b0111); adv(4'b1001);
    ld(1, 32, 4'b0000, 0); adv(4'b0000); adv(4'b0101); adv(4'b0000);
    ld(1, 33, 4'b1111, 0); idle(3);

    tag = "R9"; // linear burst from low bits 01, running past four beats
    ld(1, 17, '1, 0); for (int i = 0; i < 5; i++) adv('1);
    ld(0, 22, '0, 0); adv('0); adv('0); adv('0);
    ld(1, 20, '1, 0); adv('1); adv('1); adv('1); idle(3);

    tag = "R3"; // each deselect form, then advances that must start nothing
    ld(1, 1, '1, 0); adv('1);
    ld(1, 2, '1, 1); adv('1); adv('1);
    ld(1, 3, '1, 2); adv('1);
    ld(1, 4, '1, 3); adv('1); adv('1); idle(2);

    tag = "R4"; // pending reads finish after deselect, float after write
    ld(1, 6, '1, 0); ld(1, 7, '1, 0); idle(3);
    ld(1, 6, '1, 0); ld(0, 9, '0, 0); ld(1, 9, '1, 0); idle(3);

    tag = "R2"; // freeze mid-pipeline with garbage on the inputs
    ld(1, 3, '1, 0); ld(0, 3, 4'b1100, 0);
    cenN = 1;
    for (int i = 0; i < 3; i++) ld(0, i, 4'b0000, 0);
    cenN = 0;
    ld(1, 3, '1, 0); idle(3);

    tag = "R7"; // output enable masks without touching the pipeline
    ld(1, 40, '1, 0); ld(1, 41, '1, 0); oeN = 1; ld(1, 42, '1, 0);
    oeN = 0; ld(1, 43, '1, 0); oeN = 1; idle(1); oeN = 0; idle(3);

    tag = "R8"; // sleep keeps contents and freezes the pipeline
    ld(1, 8, '1, 0); ld(0, 8, 4'b0000, 0);
    sleep = 1;
    for (int i = 0; i < 4; i++) ld(0, 8, 4'b0000, 0);
    sleep = 0;
    idle(2); ld(1, 8, '1, 0); ld(1, 40, '1, 0); idle(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule